// File: doc/BRIEF.md
# Smart Card Byte Transmitter with Automatic Resend

This block sends bytes over a single open-drain line in the asynchronous character format that smart cards use. A host loads a byte through a simple register-style port. The transmitter sends it as a start bit, eight data bits least significant first, and a parity bit. It then releases the line for a two-etu guard period. During the guard period the receiving card may pull the line low to reject the character.

When the card rejects a character, the transmitter sets a sticky error-signal flag. It waits until the line has been idle for two etu and then sends the same byte again from its holding register, with no help from the host. The transmit-end and data-empty flags rise together only after a character has been accepted. A host or DMA engine that waits on the transmit interrupt therefore never sees a rejected character. A retry cap limits how many resends are made. When the cap is exceeded, the transfer is abandoned and a sticky overrun flag is raised.

The etu length (in clock cycles), the data width, the parity sense and the retry cap are parameters.

Top module: `sc_tx_retry`

## Requirements
- R1: After reset, the data-empty and transmit-end flags are 1, the error-signal and overrun flags are 0, and the line is released (line_oe_o = 0).
- R2: A character is sent as follows: a start bit driven low, then data bits 0 to 7, then a parity bit that makes the count of ones in data plus parity even. Each bit lasts ETU_CLKS cycles, and line_oe_o = 1 means the line is driven low. The line is released for the whole of the two-etu guard period that follows, and line_oe_o is never 1 while no transfer is in progress.
- R3: A write strobe while idle captures data_i, clears the data-empty and transmit-end flags in the following cycle, and starts the character.
- R4: The line is sampled 10.5 etu after the start edge. A low level there sets the error-signal flag, and no flag is set otherwise. eri_o is 1 whenever that flag and err_ie_i are both 1.
- R5: The error-signal flag stays set through later clean characters, and only a pulse on clr_err_i clears it.
- R6: After a rejected character, the same byte is sent again. Transmit-end stays 0 until a character passes with no error signal.
- R7: A resent start bit begins no earlier than 2 etu after the line has returned high.
- R8: After an accepted character, data-empty and transmit-end rise in the same cycle. txi_o is 1 whenever transmit-end and tx_ie_i are both 1.
- R9: A write strobe during a transfer is ignored, so every resend carries the originally written byte.
- R10: If a character is rejected after MAX_RETRY resends, the transfer stops. The overrun flag is set, while transmit-end and data-empty stay 0. clr_err_i clears the overrun flag, and the next write starts a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data_i | input | 1 | Write strobe for the transmit byte |
| data_i | input | DATA_W | Byte to transmit |
| clr_err_i | input | 1 | Clears the error-signal and overrun flags |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| line_i | input | 1 | Sensed level of the open-drain line |
| line_oe_o | output | 1 | 1 pulls the line low, 0 releases it |
| tdre_o | output | 1 | Data register empty flag |
| tend_o | output | 1 | Transmit end flag |
| ers_o | output | 1 | Error signal received flag |
| ovr_o | output | 1 | Retry cap exceeded flag |
| txi_o | output | 1 | Transmit interrupt request |
| eri_o | output | 1 | Error interrupt request |

## Verification
The bench plays the card. It rejects chosen characters by pulling the line low across the guard sampling point, sometimes for three etu, to test the R7 recovery gap. A design that raised transmit-end on a rejected character would show a frame count below the number of characters expected at the completion point. A design that reloaded from the host port instead of the holding register would send the byte written mid-transfer, and the scoreboard would report a data mismatch. The bench also checks that a later clean character does not clear the error flag. It runs past the retry cap to confirm that the transfer stops with the overrun flag set and the completion flags still clear, and that a new write starts a fresh transfer afterwards.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_FRAME   = 2'd1,
      ST_GUARD   = 2'd2,
      ST_RECOVER = 2'd3
   } tx_state_e;

   localparam int unsigned GUARD_ETUS   = 2;
   localparam int unsigned RECOVER_ETUS = 2;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
   parameter int unsigned ETU_CLKS = 372
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic etu_end_o,
   output logic mid_o
);
   localparam int unsigned CNT_W = sc_tx_pkg::idx_width(ETU_CLKS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ETU_CLKS - 1);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(ETU_CLKS / 2);

   logic [CNT_W-1:0] cnt_q;

   assign etu_end_o = (cnt_q == LAST);
   assign mid_o     = (cnt_q == MID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (clr_i)     cnt_q <= '0;
      else if (etu_end_o) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sc_parity_gen.sv
module sc_parity_gen #(
   parameter int unsigned DATA_W      = 8,
   parameter bit          EVEN_PARITY = 1'b1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic              par_o
);
   generate
      if (EVEN_PARITY) begin : g_even
         assign par_o = ^data_i;
      end else begin : g_odd
         assign par_o = ~^data_i;
      end
   endgenerate
endmodule

// File: rtl/sc_tx_ctrl.sv
module sc_tx_ctrl
   import sc_tx_pkg::*;
#(
   parameter int unsigned FRAME_W   = 10,
   parameter int unsigned MAX_RETRY = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               line_i,
   input  logic               etu_end_i,
   input  logic               mid_i,
   output logic               timer_clr_o,
   output logic               line_oe_o,
   output logic               busy_o,
   output logic               err_seen_o,
   output logic               done_o,
   output logic               giveup_o
);
   localparam int unsigned IDX_W = idx_width(FRAME_W);
   localparam int unsigned RTY_W = idx_width(MAX_RETRY + 1);
   localparam logic [IDX_W-1:0] LAST_BIT   = IDX_W'(FRAME_W - 1);
   localparam logic [IDX_W-1:0] LAST_GUARD = IDX_W'(GUARD_ETUS - 1);
   localparam logic [IDX_W-1:0] LAST_REC   = IDX_W'(RECOVER_ETUS - 1);
   localparam logic [RTY_W-1:0] RTY_CAP    = RTY_W'(MAX_RETRY);

   tx_state_e          state_q;
   logic [FRAME_W-1:0] shift_q;
   logic [IDX_W-1:0]   idx_q;
   logic [RTY_W-1:0]   retry_q;
   logic               err_q;
   logic               rec_last;

   always_comb begin
      timer_clr_o = (state_q == ST_IDLE) || (state_q == ST_RECOVER && !line_i);
      line_oe_o   = (state_q == ST_FRAME) && !shift_q[0];
      busy_o      = (state_q != ST_IDLE);
      err_seen_o  = (state_q == ST_GUARD) && (idx_q == '0) && mid_i && !line_i;
      done_o      = (state_q == ST_GUARD) && (idx_q == LAST_GUARD) && etu_end_i && !err_q;
      rec_last    = (state_q == ST_RECOVER) && line_i && etu_end_i && (idx_q == LAST_REC);
      giveup_o    = rec_last && (retry_q == RTY_CAP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         shift_q <= '1;
         idx_q   <= '0;
         retry_q <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  shift_q <= frame_i;
                  idx_q   <= '0;
                  retry_q <= '0;
                  err_q   <= 1'b0;
                  state_q <= ST_FRAME;
               end
            end
            ST_FRAME: begin
               if (etu_end_i) begin
                  if (idx_q == LAST_BIT) begin
                     idx_q   <= '0;
                     state_q <= ST_GUARD;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
                  end
               end
            end
            ST_GUARD: begin
               if (err_seen_o) err_q <= 1'b1;
               if (etu_end_i) begin
                  if (idx_q == LAST_GUARD) begin
                     idx_q   <= '0;
                     state_q <= err_q ? ST_RECOVER : ST_IDLE;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ST_RECOVER: begin
               if (!line_i) begin
                  idx_q <= '0;
               end else if (etu_end_i) begin
                  if (idx_q == LAST_REC) begin
                     idx_q <= '0;
                     if (retry_q == RTY_CAP) begin
                        state_q <= ST_IDLE;
                     end else begin
                        retry_q <= retry_q + 1'b1;
                        shift_q <= frame_i;
                        err_q   <= 1'b0;
                        state_q <= ST_FRAME;
                     end
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sc_tx_flags.sv
module sc_tx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic done_i,
   input  logic err_seen_i,
   input  logic giveup_i,
   input  logic clr_err_i,
   output logic tdre_o,
   output logic tend_o,
   output logic ers_o,
   output logic ovr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdre_o <= 1'b1;
         tend_o <= 1'b1;
         ers_o  <= 1'b0;
         ovr_o  <= 1'b0;
      end else begin
         if (start_i) begin
            tdre_o <= 1'b0;
            tend_o <= 1'b0;
         end else if (done_i) begin
            tdre_o <= 1'b1;
            tend_o <= 1'b1;
         end
         if (err_seen_i)     ers_o <= 1'b1;
         else if (clr_err_i) ers_o <= 1'b0;
         if (giveup_i)       ovr_o <= 1'b1;
         else if (clr_err_i) ovr_o <= 1'b0;
      end
   end
endmodule

// File: rtl/sc_tx_retry.sv
module sc_tx_retry #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ETU_CLKS    = 372,
   parameter int unsigned MAX_RETRY   = 4,
   parameter bit          EVEN_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              clr_err_i,
   input  logic              tx_ie_i,
   input  logic              err_ie_i,
   input  logic              line_i,
   output logic              line_oe_o,
   output logic              tdre_o,
   output logic              tend_o,
   output logic              ers_o,
   output logic              ovr_o,
   output logic              txi_o,
   output logic              eri_o
);
   localparam int unsigned FRAME_W = DATA_W + 2;

   generate
      if (ETU_CLKS < 4) begin : g_bad_etu
         $error("ETU_CLKS must be at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (MAX_RETRY < 1) begin : g_bad_retry
         $error("MAX_RETRY must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0]  hold_q;
   logic [DATA_W-1:0]  frame_data;
   logic [FRAME_W-1:0] frame;
   logic               parity;
   logic               busy;
   logic               accept;
   logic               timer_clr, etu_end, mid;
   logic               err_seen, done, giveup;

   assign accept     = wr_data_i && !busy;
   assign frame_data = busy ? hold_q : data_i;
   assign frame      = {parity, frame_data, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_q <= '0;
      else if (accept) hold_q <= data_i;
   end

   sc_parity_gen #(.DATA_W(DATA_W), .EVEN_PARITY(EVEN_PARITY)) u_par (
      .data_i (frame_data),
      .par_o  (parity)
   );

   sc_etu_timer #(.ETU_CLKS(ETU_CLKS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (timer_clr),
      .etu_end_o (etu_end),
      .mid_o     (mid)
   );

   sc_tx_ctrl #(.FRAME_W(FRAME_W), .MAX_RETRY(MAX_RETRY)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (accept),
      .frame_i     (frame),
      .line_i      (line_i),
      .etu_end_i   (etu_end),
      .mid_i       (mid),
      .timer_clr_o (timer_clr),
      .line_oe_o   (line_oe_o),
      .busy_o      (busy),
      .err_seen_o  (err_seen),
      .done_o      (done),
      .giveup_o    (giveup)
   );

   sc_tx_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (accept),
      .done_i     (done),
      .err_seen_i (err_seen),
      .giveup_i   (giveup),
      .clr_err_i  (clr_err_i),
      .tdre_o     (tdre_o),
      .tend_o     (tend_o),
      .ers_o      (ers_o),
      .ovr_o      (ovr_o)
   );

   assign txi_o = tend_o && tx_ie_i;
   assign eri_o = ers_o && err_ie_i;
endmodule

// File: rtl/sc_tx_retry_chk.sv
module sc_tx_retry_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_data_i,
   input logic clr_err_i,
   input logic err_ie_i,
   input logic busy,
   input logic line_oe_o,
   input logic tdre_o,
   input logic tend_o,
   input logic ers_o,
   input logic ovr_o,
   input logic eri_o
);
   p_drive_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe_o |-> busy);

   p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_i && !busy) |=> (busy && !tdre_o && !tend_o));

   p_eri_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ers_o) && err_ie_i) |-> eri_o);

   p_ers_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ers_o && !clr_err_i) |=> ers_o);

   p_tend_low_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !tend_o);

   p_tend_with_tdre_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tend_o) |-> $rose(tdre_o));

   p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_o && !clr_err_i) |=> ovr_o);
endmodule

bind sc_tx_retry sc_tx_retry_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_data_i (wr_data_i),
   .clr_err_i (clr_err_i),
   .err_ie_i  (err_ie_i),
   .busy      (busy),
   .line_oe_o (line_oe_o),
   .tdre_o    (tdre_o),
   .tend_o    (tend_o),
   .ers_o     (ers_o),
   .ovr_o     (ovr_o),
   .eri_o     (eri_o)
);

// File: tb/sc_tx_retry_test.sv
module sc_tx_retry_test;
   localparam int ETU  = 8;
   localparam int MAXR = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] data = 8'h00;
   logic       clr = 1'b0;
   logic       tx_ie = 1'b0;
   logic       err_ie = 1'b0;
   logic       pull = 1'b0;
   logic       line;
   logic       line_oe, tdre, tend, ers, ovr, txi, eri;

   always #2.5 clk = ~clk;
   assign line = !(line_oe || pull);

   sc_tx_retry #(.DATA_W(8), .ETU_CLKS(ETU), .MAX_RETRY(MAXR), .EVEN_PARITY(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .wr_data_i(wr), .data_i(data), .clr_err_i(clr),
      .tx_ie_i(tx_ie), .err_ie_i(err_ie), .line_i(line), .line_oe_o(line_oe),
      .tdre_o(tdre), .tend_o(tend), .ers_o(ers), .ovr_o(ovr), .txi_o(txi), .eri_o(eri)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int frames = 0;
   int rel_cyc = -1;
   logic [7:0] exp_q[$];
   int         inj_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor and card model: decode each character, compare with the scoreboard, answer in the guard time
   initial begin
      logic [9:0] fr;
      logic [7:0] e;
      int         pl;
      forever begin
         @(posedge line_oe);
         if (rel_cyc >= 0) begin
            chk(cyc - rel_cyc >= 2 * ETU, "R7 resend gap", cyc - rel_cyc, 2 * ETU);
            rel_cyc = -1;
         end
         @(negedge clk);
         repeat (ETU / 2) @(negedge clk);
         for (int k = 0; k < 10; k++) begin
            fr[k] = !line_oe;
            if (k < 9) repeat (ETU) @(negedge clk);
         end
         frames++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected character", fr, 0);
         end else begin
            e = exp_q.pop_front();
            chk(fr[0] == 1'b0, "R2 start bit", fr[0], 0);
            chk(fr[8:1] == e, "R6/R9 data byte", fr[8:1], e);
            chk(fr[9] == ^e, "R2 even parity", fr[9], ^e);
         end
         pl = (inj_q.size() != 0) ? inj_q.pop_front() : 0;
         repeat (ETU / 2 + 1) @(negedge clk);
         chk(line_oe == 1'b0, "R2 guard release", line_oe, 0);
         if (pl > 0) begin
            pull = 1'b1;
            repeat (pl * ETU) @(negedge clk);
            pull = 1'b0;
            rel_cyc = cyc;
         end
      end
   end

   // Driver: push the expected characters, write the byte, wait for completion or abandonment
   task automatic send(input logic [7:0] b, input int nerr, input int pl, input bit txie, input bit poke);
      int nfr;
      int start_frames;
      int t;
      nfr = (nerr > MAXR) ? MAXR + 1 : nerr + 1;
      for (int i = 0; i < nfr; i++) begin
         exp_q.push_back(b);
         inj_q.push_back((i < nerr) ? pl : 0);
      end
      start_frames = frames;
      tx_ie = txie;
      @(negedge clk);
      wr = 1'b1;
      data = b;
      @(negedge clk);
      wr = 1'b0;
      data = ~b;
      chk(!tdre && !tend, "R3 write clears flags", {tdre, tend}, 0);
      if (poke) begin
         repeat (3 * ETU) @(negedge clk);
         wr = 1'b1;               // R9: write during a transfer must be ignored
         data = b ^ 8'h5A;
         @(negedge clk);
         wr = 1'b0;
      end
      t = 0;
      while (!tend && !ovr && t < 20000) begin
         @(negedge clk);
         t++;
      end
      if (nerr <= MAXR) begin
         chk(tend && tdre, "R8 flags rise together", {tdre, tend}, 3);
         chk(frames - start_frames == nfr, "R6 completion withheld during resend", frames - start_frames, nfr);
         chk(txi == txie, "R8 transmit interrupt", txi, txie);
      end else begin
         chk(ovr == 1'b1, "R10 overrun flag", ovr, 1);
         chk(!tend && !tdre, "R10 completion flags stay clear", {tdre, tend}, 0);
         chk(frames - start_frames == nfr, "R10 character count", frames - start_frames, nfr);
      end
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(tdre && tend, "R1 reset completion flags", {tdre, tend}, 3);
      chk(!ers && !ovr, "R1 reset error flags", {ers, ovr}, 0);
      chk(line_oe == 1'b0, "R1 line released", line_oe, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Clean character: no error flag set (R4)
      send(8'hA5, 0, 0, 1'b1, 1'b0);
      chk(ers == 1'b0, "R4 no error on clean character", ers, 0);

      // One rejection, error interrupt enabled
      err_ie = 1'b1;
      send(8'h3C, 1, 1, 1'b0, 1'b0);
      chk(ers == 1'b1, "R4 error flag set", ers, 1);
      chk(eri == 1'b1, "R4 error interrupt", eri, 1);

      // R5 sticky flag survives time and a clean character
      repeat (50) @(negedge clk);
      chk(ers == 1'b1, "R5 flag holds while idle", ers, 1);
      send(8'h81, 0, 0, 1'b1, 1'b0);
      chk(ers == 1'b1, "R5 flag kept after clean character", ers, 1);
      pulse_clear();
      chk(ers == 1'b0, "R5 host clear", ers, 0);

      // Two rejections with a long pull (R7), plus a write during the transfer (R9)
      err_ie = 1'b0;
      send(8'hF0, 2, 3, 1'b1, 1'b1);
      chk(ers == 1'b1 && eri == 1'b0, "R4 interrupt masked", {ers, eri}, 2);
      pulse_clear();

      // Beyond the cap (R10)
      send(8'h0F, MAXR + 1, 1, 1'b1, 1'b0);
      pulse_clear();
      chk(!ovr && !ers, "R10 clear removes overrun", {ovr, ers}, 0);

      // Recovery after abandonment (R10), zero parity case
      send(8'h00, 0, 0, 1'b1, 1'b0);
      send(8'h7E, 1, 1, 1'b1, 1'b0);
      repeat (4 * ETU) @(negedge clk);
      chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule